// File: doc/BRIEF.md
# Selectable-TOP Timer/Counter with Input Capture

This block is a 16-bit up-counter whose wrap point, called TOP, is picked at run time by a mode input. TOP is either one of three fixed values or one of two programmable registers: the compare-A register or the capture register. When the counter is enabled and sits at TOP, it returns to zero on the next clock. The outputs report BOTTOM, TOP and MAX, and a compare-A match.

A single-slope PWM output is driven from compare A. The compare-A channel cannot do both jobs at once. When compare A sets the period, its writes are held in a shadow register and move into the active register only at the wrap, and the PWM output is held low. When the capture register sets the period, compare A stays free for PWM.

An external capture input passes through a majority-free noise filter, which needs four identical samples in a row. An edge detector follows the filter, and its direction is selectable. On a filtered edge the current count is copied into the capture register. The copy is skipped while that register is serving as TOP.

Top module: `tmr16_top`

## Requirements
- R1: After reset, count is 0, at_bottom is 1, at_top, at_max, pwm_out and cap_evt are 0, and cap_val is 0.
- R2: On each clock edge with cnt_en high and count not equal to TOP, count increases by one. With cnt_en low, count holds.
- R3: The mode input selects TOP as follows: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the active compare-A value, 4 gives cap_val, and 5 to 7 give 0x00FF.
- R4: at_top is high while count equals TOP. When cnt_en is high and count equals TOP, the next count is 0.
- R5: at_bottom is high exactly when count is 0x0000, and at_max is high exactly when count is 0xFFFF.
- R6: In modes other than 3, a cmpa_we write updates the active compare-A value on that edge. cmpa_match is high while count equals the active compare-A value.
- R7: In mode 3, a cmpa_we write goes only to a shadow register. The shadow is copied into the active compare-A value on the edge where the count wraps from TOP to 0.
- R8: pwm_out is high while count is below the active compare-A value and low otherwise, so it rises at BOTTOM and falls on a match. In mode 3, pwm_out is always 0.
- R9: The filtered capture level changes only after cap_in has shown the new level for four consecutive clock samples. Any shorter excursion produces no capture event.
- R10: cap_evt is a one-cycle pulse. It goes high on the fifth rising clock edge after cap_in settles at a new level, and only when that change matches cap_rise (1 selects rising, 0 selects falling). A change in the other direction gives no pulse.
- R11: On the edge after cap_evt is high, cap_val takes the count present during the pulse. In mode 4, cap_val is left unchanged by capture events. A cap_we write loads cap_wdata and takes priority over a capture on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable |
| mode | input | 3 | TOP source select |
| cmpa_we | input | 1 | Compare-A write strobe |
| cmpa_wdata | input | 16 | Compare-A write data |
| cap_we | input | 1 | Capture register write strobe |
| cap_wdata | input | 16 | Capture register write data |
| cap_in | input | 1 | External capture input |
| cap_rise | input | 1 | Capture edge select, 1 = rising |
| count | output | 16 | Counter value |
| cmpa_match | output | 1 | Count equals active compare A |
| at_bottom | output | 1 | Count is 0x0000 |
| at_top | output | 1 | Count equals TOP |
| at_max | output | 1 | Count is 0xFFFF |
| cap_evt | output | 1 | Filtered capture edge pulse |
| cap_val | output | 16 | Capture register value |
| pwm_out | output | 1 | Single-slope PWM from compare A |

## Verification
The bench writes a new compare-A value in mode 3 partway through a period. It then checks that the old TOP still ends that period and the new TOP ends the next one. A design with no shadow register would end the period early or late. It drives a three-cycle glitch and an edge in the non-selected direction, and a filter or edge detector that is too eager would capture on either. It counts the cycles from a cap_in change to cap_evt and compares the captured value with the count seen during the pulse, which exposes an off-by-one in the filter or in the capture timing. It also fires a capture in mode 4, where a design that overwrote the register would change the period. It runs one full count to 0xFFFF, where at_max and at_top must coincide and the count must then fold to zero.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [2:0] {
    TOP_FIX8  = 3'd0,
    TOP_FIX9  = 3'd1,
    TOP_FIX10 = 3'd2,
    TOP_CMPA  = 3'd3,
    TOP_CAPR  = 3'd4
  } top_mode_e;

  // TOP value chosen by the mode select
  function automatic logic [CNT_W-1:0] top_pick(input logic [2:0] m,
                                                input logic [CNT_W-1:0] cmpa,
                                                input logic [CNT_W-1:0] capr);
    case (m)
      TOP_FIX9:  top_pick = CNT_W'((1 << 9) - 1);
      TOP_FIX10: top_pick = CNT_W'((1 << 10) - 1);
      TOP_CMPA:  top_pick = cmpa;
      TOP_CAPR:  top_pick = capr;
      default:   top_pick = CNT_W'((1 << 8) - 1);
    endcase
  endfunction

  // PWM level: high from BOTTOM until compare match
  function automatic logic pwm_level(input logic [2:0] m,
                                     input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] cmpa);
    pwm_level = (m != TOP_CMPA) && (cnt < cmpa);
  endfunction
endpackage

// File: rtl/tmr16_filter.sv
module tmr16_filter #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic level,
  output logic evt
);
  logic [DEPTH-1:0] hist;
  logic             all_hi, all_lo;

  assign all_hi = &hist;
  assign all_lo = ~|hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= '0;
      level <= 1'b0;
      evt   <= 1'b0;
    end else begin
      hist <= {hist[DEPTH-2:0], din};
      if (all_hi && !level) begin
        level <= 1'b1;
        evt   <= rise_sel;
      end else if (all_lo && level) begin
        level <= 1'b0;
        evt   <= !rise_sel;
      end else begin
        evt   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] top,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = en && (count == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (wrap) count <= '0;
    else if (en)   count <= count + 1'b1;
  end
endmodule

// File: rtl/tmr16_ocr.sv
module tmr16_ocr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         buffered,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (we) shadow <= wdata;
      if (we && !buffered)      active <= wdata;
      else if (buffered && load) active <= shadow;
    end
  end
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int W       = CNT_W,
  parameter int FILT_N  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [2:0]   mode,
  input  logic         cmpa_we,
  input  logic [W-1:0] cmpa_wdata,
  input  logic         cap_we,
  input  logic [W-1:0] cap_wdata,
  input  logic         cap_in,
  input  logic         cap_rise,
  output logic [W-1:0] count,
  output logic         cmpa_match,
  output logic         at_bottom,
  output logic         at_top,
  output logic         at_max,
  output logic         cap_evt,
  output logic [W-1:0] cap_val,
  output logic         pwm_out
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] top_w;
  logic [W-1:0] cmpa_act;
  logic         wrap_w;
  logic         filt_lvl;
  logic         cmpa_is_top;
  logic         capr_is_top;

  assign cmpa_is_top = (mode == TOP_CMPA);
  assign capr_is_top = (mode == TOP_CAPR);
  assign top_w       = top_pick(mode, cmpa_act, cap_val);

  tmr16_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .top(top_w),
    .count(count), .wrap(wrap_w)
  );

  tmr16_ocr #(.W(W)) u_ocra (
    .clk(clk), .rst_n(rst_n), .we(cmpa_we), .wdata(cmpa_wdata),
    .buffered(cmpa_is_top), .load(wrap_w), .active(cmpa_act)
  );

  tmr16_filter #(.DEPTH(FILT_N)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .rise_sel(cap_rise),
    .level(filt_lvl), .evt(cap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cap_val <= '0;
    else if (cap_we)                  cap_val <= cap_wdata;
    else if (cap_evt && !capr_is_top) cap_val <= count;
  end

  assign at_bottom  = (count == '0);
  assign at_max     = (count == MAXV);
  assign at_top     = (count == top_w);
  assign cmpa_match = (count == cmpa_act);
  assign pwm_out    = pwm_level(mode, count, cmpa_act);
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic [2:0]   mode,
  input logic         cap_we,
  input logic [W-1:0] count,
  input logic         at_top,
  input logic         cap_evt,
  input logic [W-1:0] cap_val,
  input logic         pwm_out
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !at_top) |=> count == $past(count) + 1'b1);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && at_top) |=> count == '0);
  // R8
  pwm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> !pwm_out);
  // R10
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt);
  // R11
  cap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && mode != 3'd4 && !cap_we) |=> cap_val == $past(count));
  // R11
  cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !cap_we) |=> $stable(cap_val));
endmodule

bind tmr16_top tmr16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .cap_we(cap_we),
  .count(count), .at_top(at_top), .cap_evt(cap_evt), .cap_val(cap_val),
  .pwm_out(pwm_out)
);

// File: tb/tmr16_top_bench.sv
`timescale 1ns/1ps
module tmr16_top_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cnt_en = 0;
  logic [2:0]  mode = 0;
  logic        cmpa_we = 0;
  logic [15:0] cmpa_wdata = 0;
  logic        cap_we = 0;
  logic [15:0] cap_wdata = 0;
  logic        cap_in = 0;
  logic        cap_rise = 1;
  logic [15:0] count, cap_val;
  logic        cmpa_match, at_bottom, at_top, at_max, cap_evt, pwm_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr16_top u_tmr16_top (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
    .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata), .cap_we(cap_we),
    .cap_wdata(cap_wdata), .cap_in(cap_in), .cap_rise(cap_rise),
    .count(count), .cmpa_match(cmpa_match), .at_bottom(at_bottom),
    .at_top(at_top), .at_max(at_max), .cap_evt(cap_evt),
    .cap_val(cap_val), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [2:0]  m;
    logic [15:0] a;
    logic [15:0] c;
    logic [15:0] t;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd0, 16'h0000, 16'h0000, 16'h00FF},
    '{3'd1, 16'h0000, 16'h0000, 16'h01FF},
    '{3'd2, 16'h0000, 16'h0000, 16'h03FF},
    '{3'd3, 16'h0123, 16'h0000, 16'h0123},
    '{3'd4, 16'h0500, 16'h0040, 16'h0040},
    '{3'd3, 16'h0005, 16'h0700, 16'h0005},
    '{3'd6, 16'h0009, 16'h0009, 16'h00FF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    cnt_en = 0; cmpa_we = 0; cap_we = 0; mode = 0; cap_in = 0; cap_rise = 1;
    rst_n = 0;
    step();
    rst_n = 1;
    step();
  endtask

  task automatic wr_a(input logic [15:0] v);
    cmpa_we = 1; cmpa_wdata = v;
    step();
    cmpa_we = 0;
  endtask

  task automatic wr_c(input logic [15:0] v);
    cap_we = 1; cap_wdata = v;
    step();
    cap_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] seen;
    do_reset();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flags", {at_bottom, at_top, at_max, pwm_out, cap_evt}, 5'b10000);
    chk("R1 cap_val", cap_val, 0);
    // R5 bottom flag
    chk("R5 bottom", at_bottom, 1);

    // R3 / R4 table of TOP sources
    foreach (VECS[i]) begin
      do_reset();
      wr_a(VECS[i].a);
      wr_c(VECS[i].c);
      mode = VECS[i].m;
      cnt_en = 1;
      for (int k = 0; k < int'(VECS[i].t); k++) step();
      chk("R3 top reached", {count, 15'd0, at_top}, {VECS[i].t, 15'd0, 1'b1});
      step();
      chk("R4 wrap to zero", {count, 15'd0, at_bottom}, {16'd0, 15'd0, 1'b1});
    end

    // R2 enable gating
    do_reset();
    cnt_en = 1; repeat (5) step();
    chk("R2 count up", count, 5);
    cnt_en = 0; repeat (3) step();
    chk("R2 hold", count, 5);

    // R6 / R8 PWM and match in fixed mode
    do_reset();
    wr_a(16'h0030);
    cnt_en = 1;
    repeat (16'h2F) step();
    chk("R8 pwm high below", pwm_out, 1);
    chk("R6 no match", cmpa_match, 0);
    step();
    chk("R6 match", cmpa_match, 1);
    chk("R8 pwm low at match", pwm_out, 0);
    repeat (16'hD0) step();
    chk("R8 pwm high at bottom", {count, 15'd0, pwm_out}, {16'd0, 15'd0, 1'b1});

    // R7 double buffer
    do_reset();
    wr_a(16'h0010);
    mode = 3;
    cnt_en = 1;
    repeat (3) step();
    wr_a(16'h0020);
    repeat (12) step();
    chk("R7 old top kept", {count, 15'd0, at_top}, {16'h0010, 15'd0, 1'b1});
    chk("R8 pwm off in mode 3", pwm_out, 0);
    step();
    chk("R7 wrap", count, 0);
    repeat (16) step();
    chk("R7 new top not yet", {count, 15'd0, at_top}, {16'h0010, 15'd0, 1'b0});
    repeat (16) step();
    chk("R7 new top", {count, 15'd0, at_top}, {16'h0020, 15'd0, 1'b1});

    // R9 / R10 / R11 capture in fixed mode
    do_reset();
    cnt_en = 1; cap_rise = 1;
    repeat (7) step();
    cap_in = 1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R10 no early evt", cap_evt, 0);
    end
    step();
    chk("R10 evt after five edges", cap_evt, 1);
    seen = count;
    step();
    chk("R10 pulse one cycle", cap_evt, 0);
    chk("R11 captured count", cap_val, seen);
    cap_in = 0; repeat (3) step();
    cap_in = 1;
    for (int k = 0; k < 8; k++) begin
      step();
      chk("R9 glitch ignored", cap_evt, 0);
    end
    cap_in = 0;
    for (int k = 0; k < 8; k++) begin
      step();
      chk("R10 wrong edge ignored", cap_evt, 0);
    end
    chk("R9 cap_val unchanged", cap_val, seen);
    cap_rise = 0;
    cap_in = 1; repeat (8) step();
    cap_in = 0; repeat (5) step();
    chk("R10 falling edge evt", cap_evt, 1);
    seen = count;
    step();
    chk("R11 falling capture", cap_val, seen);

    // R11 capture blocked in mode 4
    do_reset();
    mode = 4;
    wr_c(16'h0040);
    cnt_en = 1; cap_rise = 1;
    cap_in = 1; repeat (5) step();
    chk("R11 evt in mode 4", cap_evt, 1);
    step();
    chk("R11 cap_val kept", cap_val, 16'h0040);

    // R5 MAX
    do_reset();
    mode = 4;
    wr_c(16'hFFFF);
    cnt_en = 1;
    for (int k = 0; k < 65535; k++) step();
    chk("R5 max flags", {count, 13'd0, at_max, at_top, at_bottom}, {16'hFFFF, 13'd0, 3'b110});
    step();
    chk("R4 wrap from max", count, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule